// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Round Unit

This block is a 16x16 multiply datapath with two state registers and a mode flag. An operand register holds one factor. A product-high register receives the upper half of the 32-bit product. A one-bit mode flag selects whether both factors are read as two's-complement or as unsigned numbers. A command, one per cycle, arrives with a valid strobe, a 3-bit opcode and a 16-bit data word. The command either loads the operand register, which also sets the mode, or multiplies that register by the data word, or writes the product-high register directly.

Multiplication comes in two forms. The truncating form keeps bits [31:16] of the product. The rounding form first adds half an LSB of the upper half (0x00008000) modulo 2^32. Because the registers are updated on the clock edge, a multiply issued in the cycle right after a load uses the value and mode that were just loaded.

Top module: `mulrnd_unit`

## Requirements
- R1: A valid command with opcode 3'd0 writes cmd_data into the operand register and clears the unsigned flag to 0 on the next clock edge.
- R2: A valid command with opcode 3'd1 writes cmd_data into the operand register and sets the unsigned flag to 1 on the next clock edge.
- R3: A valid command with opcode 3'd2 stores bits [31:16] of the 32-bit product of the operand register and cmd_data into the product-high register. When the flag is 0, both factors are two's-complement. When the flag is 1, both are unsigned.
- R4: A valid command with opcode 3'd3 forms the same product as R3, adds 0x00008000 modulo 2^32, and stores bits [31:16] of the sum into the product-high register. For example, signed -1 times 1 gives 0x0000.
- R5: Neither multiply command changes the operand register or the unsigned flag.
- R6: A valid command with opcode 3'd4 writes cmd_data into the product-high register and leaves the operand register and the flag unchanged.
- R7: When cmd_valid is low, or when the opcode is 3'd5, 3'd6 or 3'd7, all three outputs hold their values.
- R8: A synchronous active-high reset sets the product-high register, the operand register and the unsigned flag to zero.
- R9: A multiply issued in the cycle directly after an operand load uses the newly loaded value and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | DATA_W (16) | Operand accompanying the command |
| ph_q | output | DATA_W (16) | Product-high register |
| mr_q | output | DATA_W (16) | Operand register |
| um_q | output | 1 | Unsigned-mode flag (1 = unsigned) |

## Verification
The bench builds the unit at the default DATA_W of 16. At that width the extreme operands 0x8000 and 0xFFFF can be driven directly. The rounding wrap through 2^32 also shows up on the port: signed -1 times 1 rounds to 0x0000, and -32768 times 1 rounds from 0xFFFF to 0x0000. A reference model built on 64-bit integer arithmetic follows a stimulus table of mixed loads and multiplies. Directed cases then cover the round-half boundary, back-to-back load-then-multiply, reserved opcodes and idle cycles.

// File: rtl/mulrnd_pkg.sv
package mulrnd_pkg;

    typedef enum logic [2:0] {
        OP_LD_MR_S = 3'd0,
        OP_LD_MR_U = 3'd1,
        OP_MUL     = 3'd2,
        OP_MUL_RND = 3'd3,
        OP_LD_PH   = 3'd4
    } mr_op_e;

    typedef enum logic [1:0] {
        PH_SRC_DATA  = 2'd0,
        PH_SRC_TRUNC = 2'd1,
        PH_SRC_ROUND = 2'd2
    } ph_src_e;

    typedef struct packed {
        logic    ld_mr;
        logic    um_val;
        logic    wr_ph;
        ph_src_e ph_sel;
    } mr_ctrl_t;

    function automatic logic is_mul_op(input logic [2:0] op);
        return (op == OP_MUL) || (op == OP_MUL_RND);
    endfunction

endpackage

// File: rtl/mulrnd_dec.sv
module mulrnd_dec
    import mulrnd_pkg::*;
(
    input  logic       valid,
    input  logic [2:0] op,
    output mr_ctrl_t   ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.ph_sel = PH_SRC_DATA;
        if (valid) begin
            case (op)
                OP_LD_MR_S: begin
                    ctrl.ld_mr  = 1'b1;
                    ctrl.um_val = 1'b0;
                end
                OP_LD_MR_U: begin
                    ctrl.ld_mr  = 1'b1;
                    ctrl.um_val = 1'b1;
                end
                OP_MUL: begin
                    ctrl.wr_ph  = 1'b1;
                    ctrl.ph_sel = PH_SRC_TRUNC;
                end
                OP_MUL_RND: begin
                    ctrl.wr_ph  = 1'b1;
                    ctrl.ph_sel = PH_SRC_ROUND;
                end
                OP_LD_PH: begin
                    ctrl.wr_ph  = 1'b1;
                    ctrl.ph_sel = PH_SRC_DATA;
                end
                default: ctrl = '0;
            endcase
        end
    end

endmodule

// File: rtl/mulrnd_mult.sv
module mulrnd_mult #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] fac_a,
    input  logic [W-1:0] fac_b,
    input  logic         uns,
    output logic [W-1:0] hi_trunc,
    output logic [W-1:0] hi_round
);

    localparam int          PW       = 2 * W;
    localparam logic [PW-1:0] HALF_LSB = PW'(1) << (W - 1);

    logic [PW-1:0] ext_a, ext_b, prod, prod_rnd;

    // Sign or zero extension to full product width; the low PW bits of the
    // wide product equal the exact signed or unsigned product.
    always_comb begin
        ext_a = uns ? {{W{1'b0}}, fac_a} : {{W{fac_a[W-1]}}, fac_a};
        ext_b = uns ? {{W{1'b0}}, fac_b} : {{W{fac_b[W-1]}}, fac_b};
    end

    assign prod     = ext_a * ext_b;
    assign prod_rnd = prod + HALF_LSB;
    assign hi_trunc = prod[PW-1:W];
    assign hi_round = prod_rnd[PW-1:W];

    // The rounded upper half is the truncated one or one above it (mod 2^W).
    AST_RND_STEP: assert property (@(posedge clk) disable iff (rst)
        ((hi_round - hi_trunc) == W'(0)) || ((hi_round - hi_trunc) == W'(1))); // R4

endmodule

// File: rtl/mulrnd_unit.sv
module mulrnd_unit
    import mulrnd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    output logic [DATA_W-1:0] ph_q,
    output logic [DATA_W-1:0] mr_q,
    output logic              um_q
);

    mr_ctrl_t          ctrl;
    logic [DATA_W-1:0] hi_trunc, hi_round, ph_next;

    mulrnd_dec i_dec (
        .valid (cmd_valid),
        .op    (cmd_op),
        .ctrl  (ctrl)
    );

    mulrnd_mult #(.W(DATA_W)) i_mult (
        .clk      (clk),
        .rst      (rst),
        .fac_a    (mr_q),
        .fac_b    (cmd_data),
        .uns      (um_q),
        .hi_trunc (hi_trunc),
        .hi_round (hi_round)
    );

    always_comb begin
        case (ctrl.ph_sel)
            PH_SRC_TRUNC: ph_next = hi_trunc;
            PH_SRC_ROUND: ph_next = hi_round;
            default:      ph_next = cmd_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= '0;
            mr_q <= '0;
            um_q <= 1'b0;
        end else begin
            if (ctrl.ld_mr) begin
                mr_q <= cmd_data;
                um_q <= ctrl.um_val;
            end
            if (ctrl.wr_ph) begin
                ph_q <= ph_next;
            end
        end
    end

    AST_LOAD_SIGNED: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd0) |=> (mr_q == $past(cmd_data) && !um_q)); // R1

    AST_LOAD_UNSIGNED: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd1) |=> (mr_q == $past(cmd_data) && um_q)); // R2

    AST_MUL_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && is_mul_op(cmd_op)) |=> ($stable(mr_q) && $stable(um_q))); // R5

    AST_PH_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 3'd4) |=> (ph_q == $past(cmd_data) && $stable(mr_q) && $stable(um_q))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd_valid || cmd_op > 3'd4) |=> ($stable(ph_q) && $stable(mr_q) && $stable(um_q))); // R7

endmodule

// File: tb/test_mulrnd_unit.sv
module test_mulrnd_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_data = 16'd0;
    logic [15:0] ph_q, mr_q;
    logic        um_q;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Model state
    logic [15:0] m_ph = 16'd0, m_mr = 16'd0;
    logic        m_um = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    mulrnd_unit i_mulrnd_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .ph_q(ph_q), .mr_q(mr_q), .um_q(um_q)
    );

    localparam int NV = 14;
    // {opcode, data}
    localparam logic [18:0] VEC [NV] = '{
        {3'd0, 16'h1234}, {3'd2, 16'h0100}, {3'd3, 16'h00FF},
        {3'd1, 16'hF000}, {3'd2, 16'h1000}, {3'd3, 16'h0FFF},
        {3'd0, 16'hF000}, {3'd2, 16'h1000}, {3'd3, 16'hFFFF},
        {3'd4, 16'hA5A5}, {3'd1, 16'h7FFF}, {3'd3, 16'h7FFF},
        {3'd0, 16'h8001}, {3'd2, 16'h8001}
    };

    function automatic logic [15:0] ref_hi(input logic [15:0] a, input logic [15:0] b,
                                           input logic u, input logic rnd);
        longint x, y, p;
        x = u ? longint'({48'd0, a}) : longint'($signed(a));
        y = u ? longint'({48'd0, b}) : longint'($signed(b));
        p = x * y;
        if (rnd) p = p + 64'sd32768;
        return p[31:16];
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, ph_q, m_ph);
        chk(req, mr_q, m_mr);
        chk(req, {15'd0, um_q}, {15'd0, m_um});
    endtask

    // Drive at negedge; the register updates at the following posedge;
    // sample at the negedge after that.
    task automatic issue(input logic v, input logic [2:0] op, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_data = d;
        if (v) begin
            case (op)
                3'd0: begin m_mr = d; m_um = 1'b0; end
                3'd1: begin m_mr = d; m_um = 1'b1; end
                3'd2: m_ph = ref_hi(m_mr, d, m_um, 1'b0);
                3'd3: m_ph = ref_hi(m_mr, d, m_um, 1'b1);
                3'd4: m_ph = d;
                default: ;
            endcase
        end
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++; checks++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        cmd_data = 16'hDEAD;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk_all("R8 reset");

        for (int i = 0; i < NV; i++) begin
            issue(1'b1, VEC[i][18:16], VEC[i][15:0]);
            chk_all(tag_of(VEC[i][18:16]));
        end

        // R4 rounding wrap: signed -1 * 1 -> 0xFFFFFFFF + 0x8000 wraps -> 0x0000
        issue(1'b1, 3'd0, 16'hFFFF);
        issue(1'b1, 3'd2, 16'h0001);
        chk("R3 signed -1*1 trunc", ph_q, 16'hFFFF);
        issue(1'b1, 3'd3, 16'h0001);
        chk("R4 signed -1*1 round wrap", ph_q, 16'h0000);
        // R4 half boundary: unsigned 0x8000*1 = 0x00008000 -> trunc 0, round 1
        issue(1'b1, 3'd1, 16'h8000);
        issue(1'b1, 3'd2, 16'h0001);
        chk("R3 unsigned 0x8000*1", ph_q, 16'h0000);
        issue(1'b1, 3'd3, 16'h0001);
        chk("R4 unsigned half rounds up", ph_q, 16'h0001);
        // signed 0x8000*1 = 0xFFFF8000 -> trunc 0xFFFF, round 0x0000
        issue(1'b1, 3'd0, 16'h8000);
        issue(1'b1, 3'd3, 16'h0001);
        chk("R4 signed -32768 round", ph_q, 16'h0000);
        // signed -32768 * -32768 = 0x40000000
        issue(1'b1, 3'd2, 16'h8000);
        chk("R3 signed min*min", ph_q, 16'h4000);
        // unsigned 0xFFFF*0xFFFF = 0xFFFE0001
        issue(1'b1, 3'd1, 16'hFFFF);
        issue(1'b1, 3'd3, 16'hFFFF);
        chk("R4 unsigned max*max", ph_q, 16'hFFFE);
        chk("R5 mode kept after multiply", {15'd0, um_q}, 16'd1);
        chk("R5 operand kept after multiply", mr_q, 16'hFFFF);

        // R9 back-to-back: load then multiply in consecutive cycles
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_data = 16'hFFFE;   // -2 signed
        @(negedge clk);
        cmd_op = 3'd2; cmd_data = 16'h4000;                      // -2*0x4000 = 0xFFFF8000
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 back-to-back signed", ph_q, 16'hFFFF);
        chk("R9 back-to-back mode", {15'd0, um_q}, 16'd0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd1; cmd_data = 16'hFFFE;   // 65534 unsigned
        @(negedge clk);
        cmd_op = 3'd2; cmd_data = 16'h4000;                      // 0x3FFF8000
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 back-to-back unsigned", ph_q, 16'h3FFF);
        m_ph = 16'h3FFF; m_mr = 16'hFFFE; m_um = 1'b1;

        // R7 reserved opcodes and idle cycles leave all state unchanged
        for (int op = 5; op < 8; op++) begin
            issue(1'b1, 3'(op), 16'h5A5A);
            chk_all("R7 reserved opcode");
        end
        issue(1'b0, 3'd4, 16'h1111);
        chk_all("R7 invalid PH load");
        issue(1'b0, 3'd0, 16'h2222);
        chk_all("R7 invalid operand load");

        // R8 reset in mid-operation
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_ph = 16'd0; m_mr = 16'd0; m_um = 1'b0;
        chk_all("R8 reset after activity");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule